// File: doc/BRIEF.md
# Sense-Reversing Centralized Barrier

This block holds a group of `NUM_PART` participants at a series of barrier points. Each participant signals that it has reached the barrier with a one-cycle pulse on its bit of `arrive_i`. It then waits until its bit of `go_o` rises again. Inside the block there is one shared arrival counter, one global release flag and one private phase bit per participant. An accepted arrival toggles the participant's phase bit and adds one to the counter. The arrival that brings the count up to `NUM_PART` clears the counter and flips the release flag, so the flag takes the phase value that every participant now holds. A participant's `go_o` bit is high whenever its phase bit equals the release flag.

Because the wait condition compares phases and not counts, a participant that has just been released can enter the next barrier instance straight away. Its new arrival counts only toward the new instance, and the others, already released, are unaffected. No second counter is needed for this. Arrivals that occur in the same cycle are all counted together. An arrival from a participant that is already waiting is rejected and reported on `dup_err_o`.

Top module: `sense_barrier`

## Requirements
- R1: After reset, every bit of `go_o` is 1, every bit of `dup_err_o` is 0, the counter is 0 and the release flag and all phase bits are 0, so the first release needs `NUM_PART` accepted arrivals.
- R2: An arrival pulse from a participant whose `go_o` bit is 1 is accepted: that `go_o` bit is 0 from the cycle after the pulse and stays 0 until a release.
- R3: In the cycle after the accepted arrivals of an episode total `NUM_PART`, every `go_o` bit is 1. This includes the bit of the last arriver, which stays 1 without a gap.
- R4: Arrivals accepted in the same cycle are all counted in that cycle. If every participant arrives together, the release completes in that one cycle.
- R5: An arrival pulse from a participant whose `go_o` bit is 0 does not count and does not change its phase. It raises that participant's `dup_err_o` bit for exactly the next cycle.
- R6: A released participant may arrive again immediately. That arrival drops only its own `go_o` bit and counts toward the new episode. The other participants keep `go_o` at 1, and repeated episodes keep working as the phases alternate.
- R7: `dup_err_o` stays 0 for accepted arrivals, including when a duplicate and a releasing arrival occur in the same cycle.
- R8: After a release the counter starts again from 0, so the next release again needs `NUM_PART` accepted arrivals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arrive_i | input | NUM_PART | One-cycle arrival pulse per participant |
| go_o | output | NUM_PART | High while the participant is free to proceed |
| dup_err_o | output | NUM_PART | One-cycle flag for a rejected arrival |

## Verification
The hardest situation to reach is a participant arriving again in the same cycle that another participant's arrival completes the episode. At that edge the first participant is still waiting, so its pulse must be rejected and must not leak into the next episode. The stimulus reaches this point with a partial episode in which three of the four participants have arrived. It then pulses the last participant together with one of the waiting ones in a single cycle. A second difficult case is a participant that re-enters in the cycle right after a release. The checks confirm that the other participants' `go_o` bits never drop.

// File: rtl/sense_barrier_pkg.sv
package sense_barrier_pkg;

   // smallest legal participant count
   localparam int unsigned MIN_PART = 2;

   // width needed to hold values 0..n
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/sense_phase_bank.sv
module sense_phase_bank #(
   parameter int unsigned NUM_PART = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PART-1:0] accept_i,
   output logic [NUM_PART-1:0] phase_o
);

   logic [NUM_PART-1:0] phase_q;

   generate
      for (genvar g = 0; g < NUM_PART; g++) begin : g_phase
         always_ff @(posedge clk) begin
            if (!rst_n)
               phase_q[g] <= 1'b0;
            else if (accept_i[g])
               phase_q[g] <= ~phase_q[g];
         end

         // R2
         phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            accept_i[g] |=> (phase_q[g] != $past(phase_q[g])));

         // R5
         phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !accept_i[g] |=> $stable(phase_q[g]));
      end
   endgenerate

   assign phase_o = phase_q;

endmodule

// File: rtl/sense_arrival_count.sv
module sense_arrival_count
   import sense_barrier_pkg::*;
#(
   parameter int unsigned NUM_PART = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PART-1:0] accept_i,
   output logic                flag_o
);

   localparam int unsigned CNT_W = cnt_width(NUM_PART);
   localparam int unsigned SUM_W = cnt_width(2 * NUM_PART);

   logic [CNT_W-1:0] cnt_q;
   logic             flag_q;
   logic [SUM_W-1:0] pop;
   logic [SUM_W-1:0] total;
   logic             last;

   always_comb begin
      pop = '0;
      for (int i = 0; i < NUM_PART; i++)
         pop = pop + SUM_W'(accept_i[i]);
   end

   assign total = SUM_W'(cnt_q) + pop;
   assign last  = (total == SUM_W'(NUM_PART));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else if (last) begin
         cnt_q  <= '0;
         flag_q <= ~flag_q;
      end else begin
         cnt_q  <= total[CNT_W-1:0];
      end
   end

   assign flag_o = flag_q;

   // R8
   cnt_below_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CNT_W'(NUM_PART));

   // R3
   release_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q != $past(flag_q)) |-> (cnt_q == '0));

endmodule

// File: rtl/sense_barrier.sv
module sense_barrier
   import sense_barrier_pkg::*;
#(
   parameter int unsigned NUM_PART = 4,
   parameter bit          ERR_REG  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PART-1:0] arrive_i,
   output logic [NUM_PART-1:0] go_o,
   output logic [NUM_PART-1:0] dup_err_o
);

   logic [NUM_PART-1:0] phase;
   logic [NUM_PART-1:0] waiting;
   logic [NUM_PART-1:0] accept;
   logic [NUM_PART-1:0] dup;
   logic                flag;

   generate
      if (NUM_PART < MIN_PART) begin : g_bad_part
         $error("sense_barrier: NUM_PART must be at least 2");
      end
   endgenerate

   assign waiting = phase ^ {NUM_PART{flag}};
   assign accept  = arrive_i & ~waiting;
   assign dup     = arrive_i & waiting;
   assign go_o    = ~waiting;

   sense_phase_bank #(.NUM_PART(NUM_PART)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept),
      .phase_o  (phase)
   );

   sense_arrival_count #(.NUM_PART(NUM_PART)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept),
      .flag_o   (flag)
   );

   generate
      if (ERR_REG) begin : g_err_reg
         logic [NUM_PART-1:0] err_q;
         always_ff @(posedge clk) begin
            if (!rst_n) err_q <= '0;
            else        err_q <= dup;
         end
         assign dup_err_o = err_q;

         for (genvar g = 0; g < NUM_PART; g++) begin : g_err_chk
            // R5
            err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
               dup_err_o[g] |-> ($past(arrive_i[g]) && !$past(go_o[g])));
         end
      end else begin : g_err_comb
         assign dup_err_o = dup;
      end
   endgenerate

   generate
      for (genvar g = 0; g < NUM_PART; g++) begin : g_go_chk
         // R3
         go_rise_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(go_o[g]) |-> (flag != $past(flag)));
      end
   endgenerate

endmodule

// File: tb/tb_sense_barrier.sv
module tb_sense_barrier;

   localparam int unsigned NP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] arrive = '0;
   logic [NP-1:0] go;
   logic [NP-1:0] err;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   sense_barrier #(.NUM_PART(NP), .ERR_REG(1'b1)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .arrive_i  (arrive),
      .go_o      (go),
      .dup_err_o (err)
   );

   task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // pulse arrivals for one cycle, land on the following negedge
   task automatic pulse(input logic [NP-1:0] mask);
      @(negedge clk) arrive = mask;
      @(negedge clk) arrive = '0;
   endtask

   task automatic t_reset;
      check("R1 go after reset", go, 4'b1111);
      check("R1 err after reset", err, 4'b0000);
   endtask

   task automatic t_staggered;
      pulse(4'b0001); check("R2 go after p0", go, 4'b1110); check("R7 err p0", err, 4'b0000);
      pulse(4'b0010); check("R2 go after p1", go, 4'b1100);
      pulse(4'b0100); check("R2 go after p2", go, 4'b1000);
      pulse(4'b1000); check("R3 release all", go, 4'b1111);
      check("R1 first release needs all", err, 4'b0000);
   endtask

   task automatic t_simul;
      pulse(4'b1111); check("R4 all together release", go, 4'b1111);
      check("R4 no err", err, 4'b0000);
      pulse(4'b0011); check("R8 fresh count pair", go, 4'b1100);
      pulse(4'b1100); check("R4 pair completes", go, 4'b1111);
   endtask

   task automatic t_dup;
      pulse(4'b0001); check("R2 go p0", go, 4'b1110);
      pulse(4'b0001); check("R5 dup err", err, 4'b0001);
      check("R5 dup go held", go, 4'b1110);
      @(negedge clk); check("R5 err one cycle", err, 4'b0000);
      pulse(4'b0110); check("R5 dup not counted", go, 4'b1000);
      pulse(4'b1000); check("R3 release after dup", go, 4'b1111);
   endtask

   task automatic t_back2back;
      pulse(4'b0111); check("R2 three waiting", go, 4'b1000);
      pulse(4'b1000); check("R3 release", go, 4'b1111);
      pulse(4'b0001); check("R6 fast reentry", go, 4'b1110);
      pulse(4'b0010); check("R6 second entry", go, 4'b1100);
      pulse(4'b1100); check("R6 release new episode", go, 4'b1111);
      pulse(4'b0111); check("R6 partial", go, 4'b1000);
      pulse(4'b1001); check("R7 dup with last go", go, 4'b1111);
      check("R7 only dup flagged", err, 4'b0001);
      @(negedge clk); check("R7 err cleared", err, 4'b0000);
      pulse(4'b0111); check("R8 needs full count", go, 4'b1000);
      pulse(4'b1000); check("R8 release", go, 4'b1111);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_staggered();
      t_simul();
      t_dup();
      t_back2back();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule